// File: doc/BRIEF.md
# Converter Result Holding Register with Read Lock

This block keeps the most recent 10-bit converter result and presents it to a byte-wide read bus as two bytes, low and high. A format select chooses between right-justified and left-justified placement. The left-justified form lets software read only the high byte when 8-bit precision is enough. The format select acts on the stored value at once, so changing it needs no new conversion.

A read of the low byte locks the stored result until the high byte is read. This keeps the two bytes from a two-read sequence in the same conversion. A result that arrives while the lock is held is dropped. Its completion flag is still raised. The flag is cleared by writing one to it, and it raises an interrupt request when the interrupt enable is set.

Top module: `adc_result_hold`

## Requirements
- R1: After reset the stored result is zero, the register is unlocked, and both `flag_o` and `irq_o` are 0.
- R2: With `left_adj_i`=0, the low byte is result[7:0] and the high byte is {6'b0, result[9:8]}.
- R3: With `left_adj_i`=1, the high byte is result[9:2] and the low byte is {result[1:0], 6'b0}.
- R4: When unlocked and `rd_lo_i` is 0, a cycle with `res_valid_i`=1 stores `res_data_i`, and the value is readable from the next cycle.
- R5: A cycle with `rd_lo_i`=1 and `rd_hi_i`=0 locks the register from the next cycle. A result that arrives in that cycle or while locked is discarded, and both bytes keep their values.
- R6: A cycle with `rd_hi_i`=1 releases the lock from the next cycle, and later results are stored again.
- R7: A high-byte read when unlocked does not lock the register. A following result is stored.
- R8: Every cycle with `res_valid_i`=1 sets `flag_o` in the next cycle, including when the result is discarded.
- R9: `flag_clr_i`=1 clears `flag_o` in the next cycle. A set and a clear in the same cycle leave the flag set.
- R10: `irq_o` is 1 exactly when `flag_o` and `irq_en_i` are both 1.
- R11: A change of `left_adj_i` changes the presented bytes in the same cycle, with no new result.
- R12: `rdata_o` shows the high byte while `rd_hi_i`=1 and shows the low byte otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Conversion complete strobe |
| res_data_i | input | 10 | Conversion result |
| left_adj_i | input | 1 | 1 = left-justified, 0 = right-justified |
| rd_lo_i | input | 1 | Low byte read strobe |
| rd_hi_i | input | 1 | High byte read strobe |
| flag_clr_i | input | 1 | Write one to clear the completion flag |
| irq_en_i | input | 1 | Interrupt enable |
| rdata_o | output | 8 | Read data byte |
| flag_o | output | 1 | Completion flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A directed result of 0x2A5 is read in both formats, and the format select is flipped between reads. Its bit pattern separates every bit of the placement and catches shifted or swapped fields. Directed sequences cover four cases:
- a result arriving in the same cycle as a low-byte read;
- a result arriving while the lock is held;
- a high-byte read on its own;
- a flag set and clear in the same cycle.

These sequences separate the behaviour of the lock from that of the flag. A long random run mixes strobes at varied densities against a cycle model. This exposes wrong priority when lock set and release, or flag set and clear, happen together.

// File: rtl/adc_hold_pkg.sv
package adc_hold_pkg;
  typedef enum logic {
    JUST_RIGHT = 1'b0,
    JUST_LEFT  = 1'b1
  } just_e;
endpackage

// File: rtl/ahr_store.sv
module ahr_store #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [RES_W-1:0] data_i,
  input  logic             rd_lo_i,
  input  logic             rd_hi_i,
  output logic [RES_W-1:0] res_o,
  output logic             lock_o
);
  logic blocked;

  // a low read in the same cycle already protects the pair
  assign blocked = lock_o | rd_lo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o  <= '0;
      lock_o <= 1'b0;
    end else begin
      if (valid_i && !blocked) res_o <= data_i;
      if (rd_hi_i)             lock_o <= 1'b0;
      else if (rd_lo_i)        lock_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ahr_format.sv
module ahr_format
  import adc_hold_pkg::*;
#(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [RES_W-1:0]  res_i,
  input  just_e             just_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o
);
  localparam int unsigned PAIR_W = 2 * BYTE_W;
  localparam int unsigned PAD_W  = PAIR_W - RES_W;

  logic [PAIR_W-1:0] pair;

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        if (just_i == JUST_LEFT) pair = {res_i, {PAD_W{1'b0}}};
        else                     pair = {{PAD_W{1'b0}}, res_i};
      end
    end else begin : g_full
      logic unused_just;
      assign unused_just = just_i;
      assign pair = res_i;
    end
  endgenerate

  assign lo_o = pair[BYTE_W-1:0];
  assign hi_o = pair[PAIR_W-1:BYTE_W];
endmodule

// File: rtl/ahr_flag.sv
module ahr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  assign irq_o = flag_o & en_i;
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold
  import adc_hold_pkg::*;
#(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_valid_i,
  input  logic [RES_W-1:0]  res_data_i,
  input  logic              left_adj_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  input  logic              flag_clr_i,
  input  logic              irq_en_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              flag_o,
  output logic              irq_o
);
  logic [RES_W-1:0]  res_q;
  logic              lock_q;
  logic [BYTE_W-1:0] lo_byte, hi_byte;
  just_e             just;

  assign just = just_e'(left_adj_i);

  ahr_store #(.RES_W(RES_W)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (res_valid_i),
    .data_i  (res_data_i),
    .rd_lo_i (rd_lo_i),
    .rd_hi_i (rd_hi_i),
    .res_o   (res_q),
    .lock_o  (lock_q)
  );

  ahr_format #(.RES_W(RES_W), .BYTE_W(BYTE_W)) i_format (
    .res_i  (res_q),
    .just_i (just),
    .lo_o   (lo_byte),
    .hi_o   (hi_byte)
  );

  ahr_flag i_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (res_valid_i),
    .clr_i  (flag_clr_i),
    .en_i   (irq_en_i),
    .flag_o (flag_o),
    .irq_o  (irq_o)
  );

  assign rdata_o = rd_hi_i ? hi_byte : lo_byte;
endmodule

// File: rtl/ahr_checker.sv
module ahr_checker #(
  parameter int unsigned RES_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             res_valid_i,
  input logic [RES_W-1:0] res_data_i,
  input logic             rd_lo_i,
  input logic             rd_hi_i,
  input logic             flag_clr_i,
  input logic             irq_en_i,
  input logic             flag_o,
  input logic             irq_o,
  input logic [RES_W-1:0] res_q,
  input logic             lock_q
);
  AST_UPDATE_WHEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && !lock_q && !rd_lo_i |=> res_q == $past(res_data_i)); // R4
  AST_LOCK_ON_LOW_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i && !rd_hi_i |=> lock_q); // R5
  AST_LOCKED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(res_q)); // R5
  AST_HIGH_READ_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi_i |=> !lock_q); // R6
  AST_HIGH_ONLY_NO_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q && !rd_lo_i |=> !lock_q); // R7
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> flag_o); // R8
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i && !res_valid_i |=> !flag_o); // R9
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o && irq_en_i); // R10
  AST_IRQ_WHEN_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && irq_en_i |-> irq_o); // R10
endmodule

bind adc_result_hold ahr_checker #(.RES_W(RES_W)) i_ahr_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .res_valid_i (res_valid_i),
  .res_data_i  (res_data_i),
  .rd_lo_i     (rd_lo_i),
  .rd_hi_i     (rd_hi_i),
  .flag_clr_i  (flag_clr_i),
  .irq_en_i    (irq_en_i),
  .flag_o      (flag_o),
  .irq_o       (irq_o),
  .res_q       (res_q),
  .lock_q      (lock_q)
);

// File: tb/test_adc_result_hold.sv
module test_adc_result_hold;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       res_valid_i = 1'b0;
  logic [9:0] res_data_i = '0;
  logic       left_adj_i = 1'b0;
  logic       rd_lo_i = 1'b0;
  logic       rd_hi_i = 1'b0;
  logic       flag_clr_i = 1'b0;
  logic       irq_en_i = 1'b0;
  logic [7:0] rdata_o;
  logic       flag_o, irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [9:0] m_res = '0;
  logic       m_lock = 1'b0;
  logic       m_flag = 1'b0;

  always #4 clk_i = ~clk_i;

  adc_result_hold i_adc_result_hold (
    .clk_i, .rst_ni, .res_valid_i, .res_data_i, .left_adj_i,
    .rd_lo_i, .rd_hi_i, .flag_clr_i, .irq_en_i,
    .rdata_o, .flag_o, .irq_o
  );

  function automatic logic [7:0] exp_byte(logic [9:0] r, logic left, logic hi);
    logic [15:0] p;
    p = left ? {r, 6'b0} : {6'b0, r};
    return hi ? p[15:8] : p[7:0];
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, compare before the edge, then advance the model
  task automatic cycle(string tag, logic v, logic [9:0] d, logic adj,
                       logic lo, logic hi, logic clr, logic en);
    @(negedge clk_i);
    res_valid_i = v; res_data_i = d; left_adj_i = adj;
    rd_lo_i = lo; rd_hi_i = hi; flag_clr_i = clr; irq_en_i = en;
    #1;
    chk(tag, rdata_o, exp_byte(m_res, adj, hi));
    chk("R8/R9 flag", {7'b0, flag_o}, {7'b0, m_flag});
    chk("R10 irq", {7'b0, irq_o}, {7'b0, m_flag & en});
    @(posedge clk_i);
    if (v && !(m_lock || lo)) m_res = d;
    if (v) m_flag = 1'b1; else if (clr) m_flag = 1'b0;
    if (hi) m_lock = 1'b0; else if (lo) m_lock = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #20 rst_ni = 1'b1;
    cycle("R1 reset low", 0, 0, 0, 0, 0, 0, 1);
    cycle("R1 reset high", 0, 0, 1, 0, 1, 0, 1);
    // store 0x2A5 and read both formats
    cycle("R4 load", 1, 10'h2A5, 0, 0, 0, 0, 0);
    cycle("R2 low", 0, 0, 0, 1, 0, 0, 0);
    cycle("R2 high", 0, 0, 0, 0, 1, 0, 0);
    cycle("R3 high", 0, 0, 1, 0, 1, 0, 0);
    cycle("R11 low left", 0, 0, 1, 0, 0, 0, 0);
    cycle("R11 low right", 0, 0, 0, 0, 0, 0, 0);
    cycle("R9 clear", 0, 0, 0, 0, 0, 1, 1);
    // lock, then results arrive and must be dropped
    cycle("R5 lock with result", 1, 10'h155, 0, 1, 0, 0, 1);
    cycle("R5 locked result", 1, 10'h0F0, 0, 0, 0, 0, 1);
    cycle("R5 low still old", 0, 0, 0, 0, 0, 1, 1);
    cycle("R6 high release", 0, 0, 0, 0, 1, 0, 1);
    cycle("R6 load after", 1, 10'h3C3, 1, 0, 0, 0, 1);
    cycle("R6 high new", 0, 0, 1, 0, 1, 0, 1);
    // high read alone does not lock
    cycle("R7 high alone", 0, 0, 0, 0, 1, 1, 0);
    cycle("R7 load", 1, 10'h001, 0, 0, 0, 0, 0);
    cycle("R7 low new", 0, 0, 0, 0, 0, 0, 0);
    // set and clear together
    cycle("R9 set wins", 1, 10'h200, 0, 0, 0, 1, 1);
    cycle("R9 after", 0, 0, 0, 0, 0, 1, 1);
    cycle("R10 off", 0, 0, 0, 0, 0, 0, 0);
    cycle("R12 high sel", 0, 0, 1, 0, 1, 0, 0);
    begin
      void'($urandom(32'h5eed));
      for (int i = 0; i < 3000; i++) begin
        int unsigned r;
        r = $urandom;
        cycle("R12 random", r[0] & r[1], 10'($urandom), r[2],
              (r[5:3] == 0), (r[8:6] == 0), r[9] & r[10], r[11]);
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule